// File: doc/BRIEF.md
# Data Eye Center Calculator

This block turns the left and right edges of a per-lane data eye, found earlier by a delay sweep, into the value a lane delay register should hold. The edges arrive as signed abstract delays in 1/32-UI units. When `start_i` is accepted, the block walks the lanes in ascending order, one lane per clock. For each lane it forms the eye width and the upward-rounded center. It converts edges, width and center to register units through a linear base/top/mask scaling chosen by the transfer direction. It then compares the scaled width with a scaled minimum eye width.

Each lane result is presented for one cycle. The result carries the lane number, the value to load into that lane's delay register, the scaled edges and width, and a small-window flag. For writes, the loaded value is the scaled center plus the lane's write strobe delay. For reads, it is the scaled center alone. A 16-bit saved-lane vector records which lanes produced a usable eye. A done pulse with a summary error flag marks the end of the pass. The sweep, the test traffic and the register file writes are handled elsewhere.

Top module: `eye_center_calc`

## Requirements
- R1: After reset, `out_vld_o`, `done_o` and `err_o` are 0, `busy_o` is 0, and `saved_o` equals 16'hFE00.
- R2: A `start_i` sampled high while idle at clock edge E0 makes `out_vld_o` high after each edge E1..EN. After edge E(k+1), `out_lane_o` equals k. N is 9 when `ecc_en_i` is 1 at E0 and 8 when it is 0.
- R3: An abstract delay d scales to ((base + d * ((top - base) / 32)) mod 2^8) AND mask, with integer division. Base, top and mask come from the `rd_*` inputs when `dir_wr_i` is 0 and from the `wr_*` inputs when it is 1. `out_lo_o` and `out_hi_o` are the scaled low and high edges of the lane.
- R4: `out_width_o` is the scaled value of (high edge minus low edge).
- R5: The center is (low + high + 1) / 2, with the division truncating toward zero, and is then scaled.
- R6: A lane is small when its scaled width is below the scaled `min_eye_i`. In that case `out_small_o` is 1 and bit `lane` of `saved_o` stays 0. Otherwise `out_small_o` is 0 and that bit becomes 1 from the edge that presents the lane.
- R7: `out_dly_o` is the scaled center plus lane k's 8-bit field `wr_strobe_i[8k+7:8k]`, modulo 2^8, when `dir_wr_i` is 1. It is the scaled center alone when `dir_wr_i` is 0. It is produced whether or not the lane is small.
- R8: Bits 15..9 of `saved_o` are always 1. An accepted start clears bits 8..0. Bit 8 stays 0 in a pass without ECC.
- R9: `done_o` pulses for exactly the cycle in which the last lane is presented. `err_o` is the OR of the small flags of the pass and holds until the next accepted start.
- R10: `start_i` while `busy_o` is 1 is ignored. The lane sequence, the lane count and `saved_o` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a pass (accepted only when idle) |
| dir_wr_i | input | 1 | 1 = write direction, 0 = read direction |
| ecc_en_i | input | 1 | Include the ninth (check byte) lane |
| lo_dly_i | input | 72 | Signed low edge per lane, lane k at bits 8k+7:8k |
| hi_dly_i | input | 72 | Signed high edge per lane, lane k at bits 8k+7:8k |
| wr_strobe_i | input | 72 | Write strobe delay per lane, lane k at bits 8k+7:8k |
| rd_base_i | input | 8 | Read scaling base |
| rd_top_i | input | 8 | Read scaling top |
| rd_mask_i | input | 8 | Read scaling mask |
| wr_base_i | input | 8 | Write scaling base |
| wr_top_i | input | 8 | Write scaling top |
| wr_mask_i | input | 8 | Write scaling mask |
| min_eye_i | input | 8 | Signed minimum eye width, abstract units |
| busy_o | output | 1 | Pass in progress |
| out_vld_o | output | 1 | Lane result valid this cycle |
| out_lane_o | output | 4 | Lane index of the result |
| out_dly_o | output | 8 | Value for the lane delay register |
| out_lo_o | output | 8 | Scaled low edge |
| out_hi_o | output | 8 | Scaled high edge |
| out_width_o | output | 8 | Scaled eye width |
| out_small_o | output | 1 | Lane eye below minimum width |
| saved_o | output | 16 | Saved-lane vector |
| done_o | output | 1 | Pulse with the last lane result |
| err_o | output | 1 | Any small lane in the pass |

## Verification
Each lane result is due exactly one edge after the sequencer points at that lane. The result of lane k therefore appears after the (k+1)-th edge following the edge that sampled the start. The bench drives `start_i` on a falling edge and releases it one cycle later. It then steps one rising edge at a time and samples every output on the following falling edge, comparing it against values computed from the scaling formula. The saved vector, the done pulse and the held error flag are checked on the same cycle grid. A mid-pass start pulse is checked by confirming that the lane count and the idle cycle after the pass are unchanged.

// File: rtl/eyec_pkg.sv
package eyec_pkg;
   localparam int unsigned LANES_MAX = 9;
   localparam int unsigned STAT_W    = 16;
   localparam int unsigned LANE_W    = 4;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   typedef enum int unsigned {
      SC_LO   = 0,
      SC_HI   = 1,
      SC_WID  = 2,
      SC_CTR  = 3,
      SC_MINW = 4
   } scale_slot_e;

   localparam int unsigned SC_COUNT = 5;
endpackage

// File: rtl/eyec_scale.sv
module eyec_scale #(
   parameter int unsigned IW        = 10,
   parameter int unsigned RW        = 8,
   parameter int unsigned DELAY_MAX = 32
) (
   input  logic signed [IW-1:0] d_i,
   input  logic [RW-1:0]        base_i,
   input  logic [RW-1:0]        top_i,
   input  logic [RW-1:0]        mask_i,
   output logic [RW-1:0]        q_o
);
   localparam int unsigned CW = IW + RW + 2;
   localparam logic signed [CW-1:0] DMAX = CW'(DELAY_MAX);

   logic signed [CW-1:0] base_x, top_x, span, fac, d_x, prod, acc;

   always_comb begin
      base_x = $signed({{(CW-RW){1'b0}}, base_i});
      top_x  = $signed({{(CW-RW){1'b0}}, top_i});
      span   = top_x - base_x;
      fac    = span / DMAX;
      d_x    = $signed({{(CW-IW){d_i[IW-1]}}, d_i});
      prod   = d_x * fac;
      acc    = base_x + prod;
      q_o    = acc[RW-1:0] & mask_i;
   end
endmodule

// File: rtl/eyec_lane_eval.sv
module eyec_lane_eval
   import eyec_pkg::*;
#(
   parameter int unsigned DW        = 8,
   parameter int unsigned RW        = 8,
   parameter int unsigned DELAY_MAX = 32
) (
   input  logic                 dir_wr_i,
   input  logic signed [DW-1:0] lo_i,
   input  logic signed [DW-1:0] hi_i,
   input  logic [RW-1:0]        strobe_i,
   input  logic signed [DW-1:0] min_eye_i,
   input  logic [RW-1:0]        rd_base_i,
   input  logic [RW-1:0]        rd_top_i,
   input  logic [RW-1:0]        rd_mask_i,
   input  logic [RW-1:0]        wr_base_i,
   input  logic [RW-1:0]        wr_top_i,
   input  logic [RW-1:0]        wr_mask_i,
   output logic [RW-1:0]        lo_s_o,
   output logic [RW-1:0]        hi_s_o,
   output logic [RW-1:0]        wid_s_o,
   output logic [RW-1:0]        dly_o,
   output logic                 small_o
);
   localparam int unsigned IW = DW + 2;
   localparam logic signed [IW-1:0] ONE = IW'(1);
   localparam logic signed [IW-1:0] TWO = IW'(2);

   logic signed [IW-1:0] lo_x, hi_x, wid_x, sum_x, ctr_x;
   logic signed [IW-1:0] sc_in  [SC_COUNT];
   logic [RW-1:0]        sc_out [SC_COUNT];
   logic [RW-1:0]        base_sel, top_sel, mask_sel;

   always_comb begin
      lo_x  = $signed({{2{lo_i[DW-1]}}, lo_i});
      hi_x  = $signed({{2{hi_i[DW-1]}}, hi_i});
      wid_x = hi_x - lo_x;
      sum_x = lo_x + hi_x + ONE;
      ctr_x = sum_x / TWO;
      sc_in[SC_LO]   = lo_x;
      sc_in[SC_HI]   = hi_x;
      sc_in[SC_WID]  = wid_x;
      sc_in[SC_CTR]  = ctr_x;
      sc_in[SC_MINW] = $signed({{2{min_eye_i[DW-1]}}, min_eye_i});
      base_sel = dir_wr_i ? wr_base_i : rd_base_i;
      top_sel  = dir_wr_i ? wr_top_i  : rd_top_i;
      mask_sel = dir_wr_i ? wr_mask_i : rd_mask_i;
   end

   for (genvar g = 0; g < SC_COUNT; g++) begin : g_scl
      eyec_scale #(
         .IW(IW), .RW(RW), .DELAY_MAX(DELAY_MAX)
      ) u_scl (
         .d_i   (sc_in[g]),
         .base_i(base_sel),
         .top_i (top_sel),
         .mask_i(mask_sel),
         .q_o   (sc_out[g])
      );
   end

   always_comb begin
      lo_s_o  = sc_out[SC_LO];
      hi_s_o  = sc_out[SC_HI];
      wid_s_o = sc_out[SC_WID];
      small_o = sc_out[SC_WID] < sc_out[SC_MINW];
      dly_o   = dir_wr_i ? (sc_out[SC_CTR] + strobe_i) : sc_out[SC_CTR];
   end
endmodule

// File: rtl/eyec_seq.sv
module eyec_seq
   import eyec_pkg::*;
#(
   parameter int unsigned BASE_LANES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ecc_en_i,
   output logic              accept_o,
   output logic              step_o,
   output logic              last_o,
   output logic [LANE_W-1:0] lane_o
);
   localparam logic [LANE_W-1:0] LAST_PLAIN = LANE_W'(BASE_LANES - 1);
   localparam logic [LANE_W-1:0] LAST_ECC   = LANE_W'(BASE_LANES);

   seq_state_e        st_q;
   logic [LANE_W-1:0] lane_q, last_q;

   assign accept_o = (st_q == SEQ_IDLE) && start_i;
   assign step_o   = (st_q == SEQ_RUN);
   assign last_o   = step_o && (lane_q == last_q);
   assign lane_o   = lane_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         lane_q <= '0;
         last_q <= LAST_PLAIN;
      end else if (accept_o) begin
         st_q   <= SEQ_RUN;
         lane_q <= '0;
         last_q <= ecc_en_i ? LAST_ECC : LAST_PLAIN;
      end else if (step_o) begin
         if (last_o) begin
            st_q <= SEQ_IDLE;
         end else begin
            lane_q <= lane_q + 1'b1;
         end
      end
   end

   // R2: the lane pointer never passes the last lane of the pass
   a_r2_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> (lane_q <= last_q));
   // R2: the lane pointer advances by one while running
   a_r2_lane_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && !last_o) |=> (step_o && lane_q == $past(lane_q) + 1'b1));
endmodule

// File: rtl/eye_center_calc.sv
module eye_center_calc
   import eyec_pkg::*;
#(
   parameter int unsigned LANES     = 9,
   parameter int unsigned DW        = 8,
   parameter int unsigned RW        = 8,
   parameter int unsigned DELAY_MAX = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 dir_wr_i,
   input  logic                 ecc_en_i,
   input  logic [LANES*DW-1:0]  lo_dly_i,
   input  logic [LANES*DW-1:0]  hi_dly_i,
   input  logic [LANES*RW-1:0]  wr_strobe_i,
   input  logic [RW-1:0]        rd_base_i,
   input  logic [RW-1:0]        rd_top_i,
   input  logic [RW-1:0]        rd_mask_i,
   input  logic [RW-1:0]        wr_base_i,
   input  logic [RW-1:0]        wr_top_i,
   input  logic [RW-1:0]        wr_mask_i,
   input  logic [DW-1:0]        min_eye_i,
   output logic                 busy_o,
   output logic                 out_vld_o,
   output logic [LANE_W-1:0]    out_lane_o,
   output logic [RW-1:0]        out_dly_o,
   output logic [RW-1:0]        out_lo_o,
   output logic [RW-1:0]        out_hi_o,
   output logic [RW-1:0]        out_width_o,
   output logic                 out_small_o,
   output logic [STAT_W-1:0]    saved_o,
   output logic                 done_o,
   output logic                 err_o
);
   localparam int unsigned BASE_LANES = LANES - 1;
   localparam logic [STAT_W-1:0] STAT_INIT =
      ~((STAT_W'(1) << LANES) - STAT_W'(1));

   if (LANES < 2 || LANES > LANES_MAX) begin : g_bad_lanes
      $error("eye_center_calc: LANES out of range");
   end
   if (DELAY_MAX < 1) begin : g_bad_dmax
      $error("eye_center_calc: DELAY_MAX must be positive");
   end
   if (DW < 2 || RW < 2) begin : g_bad_width
      $error("eye_center_calc: widths too small");
   end

   logic                 accept, step, last;
   logic [LANE_W-1:0]    lane;
   logic signed [DW-1:0] lo_arr [LANES];
   logic signed [DW-1:0] hi_arr [LANES];
   logic [RW-1:0]        st_arr [LANES];
   logic signed [DW-1:0] lo_sel, hi_sel;
   logic [RW-1:0]        st_sel;
   logic [RW-1:0]        lo_s, hi_s, wid_s, dly_s;
   logic                 small_s;
   logic [STAT_W-1:0]    saved_q;

   eyec_seq #(.BASE_LANES(BASE_LANES)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .ecc_en_i(ecc_en_i),
      .accept_o(accept),
      .step_o  (step),
      .last_o  (last),
      .lane_o  (lane)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign lo_arr[g] = $signed(lo_dly_i[g*DW +: DW]);
      assign hi_arr[g] = $signed(hi_dly_i[g*DW +: DW]);
      assign st_arr[g] = wr_strobe_i[g*RW +: RW];
   end

   always_comb begin
      lo_sel = '0;
      hi_sel = '0;
      st_sel = '0;
      for (int i = 0; i < LANES; i++) begin
         if (lane == LANE_W'(i)) begin
            lo_sel = lo_arr[i];
            hi_sel = hi_arr[i];
            st_sel = st_arr[i];
         end
      end
   end

   eyec_lane_eval #(
      .DW(DW), .RW(RW), .DELAY_MAX(DELAY_MAX)
   ) u_eval (
      .dir_wr_i (dir_wr_i),
      .lo_i     (lo_sel),
      .hi_i     (hi_sel),
      .strobe_i (st_sel),
      .min_eye_i($signed(min_eye_i)),
      .rd_base_i(rd_base_i),
      .rd_top_i (rd_top_i),
      .rd_mask_i(rd_mask_i),
      .wr_base_i(wr_base_i),
      .wr_top_i (wr_top_i),
      .wr_mask_i(wr_mask_i),
      .lo_s_o   (lo_s),
      .hi_s_o   (hi_s),
      .wid_s_o  (wid_s),
      .dly_o    (dly_s),
      .small_o  (small_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld_o   <= 1'b0;
         out_lane_o  <= '0;
         out_dly_o   <= '0;
         out_lo_o    <= '0;
         out_hi_o    <= '0;
         out_width_o <= '0;
         out_small_o <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         out_vld_o <= step;
         done_o    <= last;
         if (step) begin
            out_lane_o  <= lane;
            out_dly_o   <= dly_s;
            out_lo_o    <= lo_s;
            out_hi_o    <= hi_s;
            out_width_o <= wid_s;
            out_small_o <= small_s;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saved_q <= STAT_INIT;
         err_o   <= 1'b0;
      end else if (accept) begin
         saved_q <= STAT_INIT;
         err_o   <= 1'b0;
      end else if (step) begin
         if (small_s) begin
            err_o <= 1'b1;
         end else begin
            saved_q[lane] <= 1'b1;
         end
      end
   end

   assign saved_o = saved_q;
   assign busy_o  = step;

   // R2: a result appears only on the cycle after a running cycle
   a_r2_vld_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> $past(step));
   // R9: the done pulse comes with the last result
   a_r9_done_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> out_vld_o);
   // R9: done lasts one cycle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8: upper status bits stay set
   a_r8_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
      saved_o[STAT_W-1:LANES] == '1);
   // R6: a small lane is never marked saved
   a_r6_small_not_saved: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld_o && out_small_o) |-> !saved_o[out_lane_o]);
   // R6: a lane with a wide enough eye is marked saved
   a_r6_ok_saved: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld_o && !out_small_o) |-> saved_o[out_lane_o]);
   // R9: any small lane raises the summary flag
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld_o && out_small_o) |-> err_o);
endmodule

// File: tb/eye_center_calc_bench.sv
`timescale 1ns/1ps
module eye_center_calc_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        start_i = 0, dir_wr_i = 0, ecc_en_i = 0;
   logic [71:0] lo_dly_i, hi_dly_i, wr_strobe_i;
   logic [7:0]  rd_base_i = 8'h10, rd_top_i = 8'h50, rd_mask_i = 8'hFF;
   logic [7:0]  wr_base_i = 8'h00, wr_top_i = 8'h60, wr_mask_i = 8'h7F;
   logic [7:0]  min_eye_i = 8'd4;
   logic        busy_o, out_vld_o, out_small_o, done_o, err_o;
   logic [3:0]  out_lane_o;
   logic [7:0]  out_dly_o, out_lo_o, out_hi_o, out_width_o;
   logic [15:0] saved_o;

   int lo[9];
   int hi[9];
   int st[9];
   int total = 0;
   int bad = 0;

   always_comb begin
      for (int i = 0; i < 9; i++) begin
         lo_dly_i[i*8 +: 8]    = 8'(lo[i]);
         hi_dly_i[i*8 +: 8]    = 8'(hi[i]);
         wr_strobe_i[i*8 +: 8] = 8'(st[i]);
      end
   end

   eye_center_calc u_eye_center_calc (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_wr_i(dir_wr_i),
      .ecc_en_i(ecc_en_i), .lo_dly_i(lo_dly_i), .hi_dly_i(hi_dly_i),
      .wr_strobe_i(wr_strobe_i), .rd_base_i(rd_base_i), .rd_top_i(rd_top_i),
      .rd_mask_i(rd_mask_i), .wr_base_i(wr_base_i), .wr_top_i(wr_top_i),
      .wr_mask_i(wr_mask_i), .min_eye_i(min_eye_i), .busy_o(busy_o),
      .out_vld_o(out_vld_o), .out_lane_o(out_lane_o), .out_dly_o(out_dly_o),
      .out_lo_o(out_lo_o), .out_hi_o(out_hi_o), .out_width_o(out_width_o),
      .out_small_o(out_small_o), .saved_o(saved_o), .done_o(done_o),
      .err_o(err_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int scl(input int d, input bit wr);
      int b, t, m, f;
      b = wr ? int'(wr_base_i) : int'(rd_base_i);
      t = wr ? int'(wr_top_i)  : int'(rd_top_i);
      m = wr ? int'(wr_mask_i) : int'(rd_mask_i);
      f = (t - b) / 32;
      return (b + d * f) & 255 & m;
   endfunction

   // runs one pass; pulses start mid-pass at lane poke (if >= 0)
   task automatic run_pass(input bit wr, input bit ecc, input int poke);
      int n, ctr, wid, minw, dly, exp_saved, exp_err;
      bit sm;
      n = ecc ? 9 : 8;
      exp_saved = 16'hFE00;
      exp_err = 0;
      @(negedge clk);
      dir_wr_i = wr; ecc_en_i = ecc; start_i = 1;
      @(posedge clk);
      @(negedge clk);
      start_i = 0;
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == poke) start_i = 1;
         if (k == poke + 1) start_i = 0;
         ctr  = (lo[k] + hi[k] + 1) / 2;
         wid  = scl(hi[k] - lo[k], wr);
         minw = scl($signed(min_eye_i), wr);
         sm   = wid < minw;
         dly  = wr ? ((scl(ctr, wr) + st[k]) & 255) : scl(ctr, wr);
         if (!sm) exp_saved |= (1 << k);
         else exp_err = 1;
         chk("R2", "valid", int'(out_vld_o), 1);
         chk("R2", "lane", int'(out_lane_o), k);
         chk("R3", "lo", int'(out_lo_o), scl(lo[k], wr));
         chk("R3", "hi", int'(out_hi_o), scl(hi[k], wr));
         chk("R4", "width", int'(out_width_o), wid);
         chk("R5_R7", "dly", int'(out_dly_o), dly);
         chk("R6", "small", int'(out_small_o), int'(sm));
         chk("R6", "saved", int'(saved_o), exp_saved);
         chk("R9", "done", int'(done_o), int'(k == n - 1));
      end
      start_i = 0;
      @(posedge clk);
      @(negedge clk);
      chk("R10", "no extra lane", int'(out_vld_o), 0);
      chk("R9", "done cleared", int'(done_o), 0);
      repeat (3) @(negedge clk);
      chk("R9", "err held", int'(err_o), exp_err);
      chk("R8", "saved held", int'(saved_o), exp_saved);
      chk("R8", "lane8 without ecc", int'(saved_o[8]), ecc ? int'(saved_o[8]) : 0);
   endtask

   task automatic t_reset();
      chk("R1", "vld", int'(out_vld_o), 0);
      chk("R1", "done", int'(done_o), 0);
      chk("R1", "err", int'(err_o), 0);
      chk("R1", "busy", int'(busy_o), 0);
      chk("R1", "saved", int'(saved_o), 16'hFE00);
   endtask

   task automatic t_read_plain();
      lo = '{2, 0, -3, 5, 1, -1, 4, 0, 0};
      hi = '{20, 18, 14, 25, 3, 17, 22, 9, 6};
      st = '{5, 6, 7, 8, 9, 10, 11, 12, 13};
      rd_mask_i = 8'hFF;
      run_pass(1'b0, 1'b0, -5);
   endtask

   task automatic t_write_ecc();
      lo = '{-9, 1, -4, 2, 0, 3, -1, 6, -2};
      hi = '{-2, 30, 11, 4, 25, 19, 0, 28, 30};
      st = '{3, 200, 16, 0, 255, 40, 7, 90, 1};
      run_pass(1'b1, 1'b1, -5);
   endtask

   task automatic t_mask_ecc();
      lo = '{1, 2, 3, 4, 5, 6, 7, 8, -8};
      hi = '{31, 12, 13, 30, 15, 26, 17, 28, 8};
      rd_mask_i = 8'hF0;
      min_eye_i = 8'd6;
      run_pass(1'b0, 1'b1, -5);
      rd_mask_i = 8'hFF;
      min_eye_i = 8'd4;
   endtask

   task automatic t_start_ignored();
      lo = '{0, 1, 2, 3, 4, 5, 6, 7, 8};
      hi = '{10, 11, 12, 13, 14, 15, 16, 17, 18};
      run_pass(1'b1, 1'b0, 2);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      lo = '{default: 0};
      hi = '{default: 0};
      st = '{default: 0};
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_read_plain();
      t_write_ecc();
      t_mask_ecc();
      t_start_ignored();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule